// File: doc/BRIEF.md
# Maskable Interrupt Collector with Pin Change Detection

This block gathers eight interrupt conditions from two serial channels, a counter and a set of input pins. It holds them in a status vector and drives one active-low request line whenever a condition is pending and its mask bit is set. Each condition is held in a sticky flag. A source sets its flag with a one-cycle event pulse. The flag clears only through the event that services that source: reading received data, writing transmit data, a break-clear command, a counter-stop command, or reading the change register.

Four input pins pass through a synchronizer and an edge detector. Any level change on a pin sets a sticky delta bit for that pin. The OR of the four delta bits is the eighth condition. A small register port lets the CPU read the status, read and write the mask, read the change register, and write a routing register. The routing register sends up to six of the conditions to separate active-low outputs, and these outputs do not depend on the mask.

Top module: `irq_cos_unit`

## Requirements
- R1: After reset the status, mask and routing registers read 0, every delta bit is 0, `irq_n` is 1 and every `src_irq_n` bit is 1.
- R2: `irq_n` is 0 exactly when some status bit and the mask bit at the same position are both 1. The status vector (address 0) has this layout: bit0 tx A, bit1 rx A, bit2 break A, bit3 counter, bit4 tx B, bit5 rx B, bit6 break B, bit7 pin change.
- R3: An `rx_evt[c]` pulse sets the rx flag of channel c from the next cycle on. A `rx_rd[c]` pulse clears it. If both arrive in the same cycle, the flag is set.
- R4: A `tx_wr[c]` pulse clears the tx flag of channel c, which is set by `tx_evt[c]`.
- R5: A `brk_clr[c]` pulse clears the break flag of channel c. A `ctr_stop` pulse clears the counter flag.
- R6: A write to address 1 loads the mask. Clearing a mask bit releases `irq_n` in the next cycle and leaves the status unchanged.
- R7: When an input pin changes level, its delta bit is set after the third rising clock edge that follows the change, and not before. The delta bit then stays set.
- R8: Address 2 reads as {delta[3:0], synchronized levels[3:0]}. A read with `bus_re` clears the delta bits, except a bit whose pin edge is detected in the same cycle. Status bit 7 is the OR of the delta bits.
- R9: A write to address 3 loads the routing register. `src_irq_n[i]` is 0 exactly when status bit i and routing bit i are both 1, whatever the mask.
- R10: Writes to addresses 0 and 2 change nothing. Reading address 0 or 1 has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_evt | input | 2 | Transmit-ready set pulse, per channel |
| rx_evt | input | 2 | Receive-ready set pulse, per channel |
| brk_evt | input | 2 | Break-change set pulse, per channel |
| ctr_evt | input | 1 | Counter set pulse |
| tx_wr | input | 2 | Transmit data write (clears tx flag) |
| rx_rd | input | 2 | Receive data read (clears rx flag) |
| brk_clr | input | 2 | Break-clear command |
| ctr_stop | input | 1 | Counter-stop command |
| in_pins | input | 4 | Asynchronous input pins, idle high |
| bus_re | input | 1 | Read strobe (side effects only) |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_n | output | 1 | Combined active-low request |
| src_irq_n | output | 6 | Routed active-low per-condition requests |

## Verification
The properties assume that event and clear inputs are single-cycle pulses that are synchronous to `clk`. They also assume that `in_pins` is high while reset is asserted, because the synchronizer resets to the idle-high level. The stimulus changes every input on the falling clock edge and holds each pulse for exactly one cycle. It changes a pin only after the earlier change on that pin has been fully detected, so each edge check sees a single transition.

// File: rtl/irq_cos_pkg.sv
package irq_cos_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CHG   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ROUTE = 2'd3;

  // request is pending when any enabled condition is set
  function automatic logic any_pending(input logic [DATA_W-1:0] stat,
                                       input logic [DATA_W-1:0] msk);
    return |(stat & msk);
  endfunction

  // change register word: deltas on top, live levels below
  function automatic logic [7:0] chg_word(input logic [3:0] delta,
                                          input logic [3:0] lvl);
    return {delta, lvl};
  endfunction

  // sticky update: set has priority over clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cos_detector.sv
module cos_detector #(
  parameter int unsigned N_PINS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  input  logic              clr,
  output logic [N_PINS-1:0] level,
  output logic [N_PINS-1:0] edge_det,
  output logic [N_PINS-1:0] delta
);
  import irq_cos_pkg::*;

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_PINS-1:0] sync_q [SYNC_STAGES];
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '1;
    else        sync_q[0] <= pins;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '1;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign level    = sync_q[LAST];
  assign edge_det = level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= level;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_delta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) delta_q[p] <= 1'b0;
      else        delta_q[p] <= sticky_next(delta_q[p], edge_det[p], clr);
    end
  end

  assign delta = delta_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_FLAGS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_vec,
  input  logic [N_FLAGS-1:0] clr_vec,
  output logic [N_FLAGS-1:0] flags
);
  import irq_cos_pkg::*;

  logic [N_FLAGS-1:0] flag_q;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= sticky_next(flag_q[i], set_vec[i], clr_vec[i]);
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_cos_unit.sv
module irq_cos_unit #(
  parameter int unsigned N_COS       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_ROUTE     = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        tx_evt,
  input  logic [1:0]                        rx_evt,
  input  logic [1:0]                        brk_evt,
  input  logic                              ctr_evt,
  input  logic [1:0]                        tx_wr,
  input  logic [1:0]                        rx_rd,
  input  logic [1:0]                        brk_clr,
  input  logic                              ctr_stop,
  input  logic [N_COS-1:0]                  in_pins,
  input  logic                              bus_re,
  input  logic                              bus_we,
  input  logic [irq_cos_pkg::ADDR_W-1:0]    bus_addr,
  input  logic [irq_cos_pkg::DATA_W-1:0]    bus_wdata,
  output logic [irq_cos_pkg::DATA_W-1:0]    bus_rdata,
  output logic                              irq_n,
  output logic [N_ROUTE-1:0]                src_irq_n
);
  import irq_cos_pkg::*;

  localparam int unsigned N_FLAGS = DATA_W - 1;

  logic [N_FLAGS-1:0] set_vec, clr_vec, flags;
  logic [N_COS-1:0]   cos_level, cos_edge, delta_q;
  logic [DATA_W-1:0]  stat_vec, mask_q, route_q;
  logic               chg_rd, wr_mask, wr_route;

  // flag order matches status bits 6..0
  assign set_vec = {brk_evt[1], rx_evt[1], tx_evt[1], ctr_evt,
                    brk_evt[0], rx_evt[0], tx_evt[0]};
  assign clr_vec = {brk_clr[1], rx_rd[1], tx_wr[1], ctr_stop,
                    brk_clr[0], rx_rd[0], tx_wr[0]};

  assign chg_rd   = bus_re && (bus_addr == ADDR_CHG);
  assign wr_mask  = bus_we && (bus_addr == ADDR_MASK);
  assign wr_route = bus_we && (bus_addr == ADDR_ROUTE);

  irq_flag_bank #(.N_FLAGS(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags(flags)
  );

  cos_detector #(.N_PINS(N_COS), .SYNC_STAGES(SYNC_STAGES)) u_cos (
    .clk(clk), .rst_n(rst_n), .pins(in_pins), .clr(chg_rd),
    .level(cos_level), .edge_det(cos_edge), .delta(delta_q)
  );

  assign stat_vec = {|delta_q, flags};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= bus_wdata;
      if (wr_route) route_q <= bus_wdata;
    end
  end

  assign irq_n = ~any_pending(stat_vec, mask_q);

  for (genvar i = 0; i < N_ROUTE; i++) begin : g_route
    assign src_irq_n[i] = ~(stat_vec[i] & route_q[i]);
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_STAT: bus_rdata = stat_vec;
      ADDR_MASK: bus_rdata = mask_q;
      ADDR_CHG:  bus_rdata = chg_word(delta_q, cos_level);
      default:   bus_rdata = route_q;
    endcase
  end
endmodule

// File: rtl/irq_cos_chk.sv
module irq_cos_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_evt,
  input logic [1:0] rx_rd,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       irq_n,
  input logic [7:0] stat_vec,
  input logic [7:0] mask_q,
  input logic [7:0] route_q,
  input logic [3:0] cos_edge,
  input logic [3:0] delta_q,
  input logic       chg_rd,
  input logic [5:0] src_irq_n
);
  // R3
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt[0] |=> stat_vec[1]);
  // R3
  rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd[0] && !rx_evt[0]) |=> !stat_vec[1]);
  // R6
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && bus_wdata == 8'h00) |=> irq_n);
  // R7
  cos_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cos_edge) |=> ((delta_q & $past(cos_edge)) == $past(cos_edge)));
  // R8
  chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_rd && cos_edge == 4'h0) |=> (delta_q == 4'h0));
  // R9
  route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == 8'h00) |-> (&src_irq_n));
  // R2
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> irq_n);
endmodule

bind irq_cos_unit irq_cos_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .rx_rd(rx_rd),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_n(irq_n), .stat_vec(stat_vec), .mask_q(mask_q), .route_q(route_q),
  .cos_edge(cos_edge), .delta_q(delta_q), .chg_rd(chg_rd),
  .src_irq_n(src_irq_n)
);

// File: tb/irq_cos_unit_bench.sv
module irq_cos_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tx_evt = '0, rx_evt = '0, brk_evt = '0;
  logic       ctr_evt = 1'b0;
  logic [1:0] tx_wr = '0, rx_rd = '0, brk_clr = '0;
  logic       ctr_stop = 1'b0;
  logic [3:0] in_pins = 4'hF;
  logic       bus_re = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_n;
  logic [5:0] src_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_cos_unit u_irq_cos_unit (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .brk_evt(brk_evt), .ctr_evt(ctr_evt), .tx_wr(tx_wr), .rx_rd(rx_rd),
    .brk_clr(brk_clr), .ctr_stop(ctr_stop), .in_pins(in_pins),
    .bus_re(bus_re), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
    .src_irq_n(src_irq_n)
  );

  // {set7, clr7, mask, expected status, expected irq_n}; set/clr bit i = status bit i
  localparam logic [30:0] VEC [8] = '{
    {7'b0000011, 7'b0000000, 8'h00, 8'h03, 1'b1},
    {7'b0000000, 7'b0000000, 8'h02, 8'h03, 1'b0},
    {7'b0000000, 7'b0000010, 8'h02, 8'h01, 1'b1},
    {7'b1110000, 7'b0000001, 8'h40, 8'h70, 1'b0},
    {7'b0001000, 7'b1000000, 8'h08, 8'h38, 1'b0},
    {7'b0000000, 7'b0001000, 8'h08, 8'h30, 1'b1},
    {7'b0100000, 7'b0100000, 8'h20, 8'h30, 1'b0},
    {7'b0000000, 7'b0110000, 8'hFF, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] s, input logic [6:0] c);
    @(negedge clk);
    tx_evt = {s[4], s[0]}; rx_evt = {s[5], s[1]};
    brk_evt = {s[6], s[2]}; ctr_evt = s[3];
    tx_wr = {c[4], c[0]}; rx_rd = {c[5], c[1]};
    brk_clr = {c[6], c[2]}; ctr_stop = c[3];
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; brk_evt = '0; ctr_evt = 1'b0;
    tx_wr = '0; rx_rd = '0; brk_clr = '0; ctr_stop = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 8'h00);
    rd(2'd1, d); check("R1 mask", d, 8'h00);
    rd(2'd3, d); check("R1 route", d, 8'h00);
    rd(2'd2, d); check("R1 change", d, 8'h0F);
    check("R1 irq_n", irq_n, 1'b1);
    check("R1 src_irq_n", src_irq_n, 6'h3F);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, VEC[i][16:9]);
      pulse(VEC[i][30:24], VEC[i][23:17]);
      rd(2'd0, d);
      check($sformatf("R2/R3/R4/R5 vec%0d status", i), d, VEC[i][8:1]);
      check($sformatf("R2 vec%0d irq_n", i), irq_n, VEC[i][0]);
    end

    // R6 clearing mask releases request, status kept
    pulse(7'b0000010, 7'b0);
    check("R6 irq asserted", irq_n, 1'b0);
    wr(2'd1, 8'h00);
    check("R6 irq released", irq_n, 1'b1);
    rd(2'd0, d); check("R6 status kept", d, 8'h02);
    pulse(7'b0, 7'b0000010);

    // R7 detection latency on pin 0
    @(negedge clk); in_pins = 4'hE;
    @(negedge clk); @(negedge clk);
    rd(2'd0, d); check("R7 not yet", d, 8'h00);
    @(negedge clk);
    rd(2'd0, d); check("R7 delta set", d, 8'h80);
    repeat (3) @(negedge clk);
    rd(2'd2, d); check("R7 sticky", d, 8'h1E);
    wr(2'd1, 8'h80);
    check("R2 pin change irq", irq_n, 1'b0);

    // R8 read clears delta
    @(negedge clk); bus_addr = 2'd2; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    rd(2'd2, d); check("R8 cleared", d, 8'h0E);
    check("R8 irq released", irq_n, 1'b1);

    // R8 edge coinciding with read keeps delta
    in_pins = 4'hC;
    @(negedge clk); @(negedge clk);
    bus_addr = 2'd2; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    rd(2'd2, d); check("R8 edge wins", d, 8'h2C);

    // R9 routing independent of mask
    pulse(7'b0000001, 7'b0);
    check("R9 route off", src_irq_n, 6'h3F);
    wr(2'd3, 8'h01);
    check("R9 routed", src_irq_n, 6'h3E);
    wr(2'd1, 8'h00);
    check("R9 ignores mask", src_irq_n, 6'h3E);

    // R10 writes to read-only addresses, side-effect-free reads
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R10 status untouched", d, 8'h81);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R10 change untouched", d, 8'h2C);
    @(negedge clk); bus_addr = 2'd0; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    rd(2'd0, d); check("R10 status read no clear", d, 8'h81);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule